// File: doc/BRIEF.md
# Quad-SPI Register and FIFO Control Unit

This block is the register-facing half of a quad-SPI flash engine. Software programs it over a simple 32-bit register bus, and it holds the configuration fields, the command word and the status flags. It also drives the control handshake to a separate phase sequencer, which does the serial shifting. Payload bytes pass through a byte-wide FIFO. The host side fills it for write commands and drains it for read commands. The sequencer does the opposite, and the direction is taken from the most recently accepted command.

A command starts when software writes the command register while the unit is enabled, idle and not aborting. The unit then reports busy and pulses a start strobe to the sequencer. While busy, it produces a serial-clock enable at the kernel clock divided by (prescaler + 1). The sequencer reports completion or error. Each outcome sets a sticky flag, and each flag can raise the interrupt through its own enable. A separate write-one-to-clear register clears the flags. Abort is a self-clearing request: it flushes the FIFO, holds the sequencer in abort, and is dropped by hardware only once the sequencer reports idle.

Top module: `qspi_ctl_unit`

## Requirements
- R1: After synchronous reset the control and command registers read 0. The status register reads 0x0000_0004 (only the threshold flag, since the empty FIFO has free space in write direction). irq, seq_start, seq_abort and sck_tick are low.
- R2: The control register (offset 0x0) holds enable in bit 0, abort in bit 1, DMA enable in bit 2, the FIFO threshold in bits from 8 upward (log2 of FIFO depth wide), the error interrupt enable in bit 16, the complete interrupt enable in bit 17 and an 8-bit prescaler in bits 31..24. Unimplemented bits read 0.
- R3: A write to the command register (offset 0xC) is accepted only when enable is 1, busy is 0 and abort is 0. An accepted write stores the word on seq_cmd, sets busy and pulses seq_start for exactly one cycle. Any other write leaves seq_cmd unchanged and produces no start.
- R4: While busy, seq_done clears busy and sets the complete flag, and seq_err clears busy and sets the error flag. The status register (offset 0x4) shows error in bit 0, complete in bit 1, threshold in bit 2, busy in bit 5 and FIFO level in bits 13..8.
- R5: Writing 1 to bit 0 of the flag-clear register (offset 0x8) clears the error flag, and writing 1 to bit 1 clears the complete flag. Writing 0 has no effect. A flag set in the same cycle as its clear stays set.
- R6: irq is high exactly when (complete flag and complete enable) or (error flag and error enable).
- R7: The FIFO keeps bytes in first-in first-out order, up to DEPTH (16) entries. A push when full is dropped, and a pop when empty changes nothing.
- R8: The direction is bit 31 of the last accepted command: 1 means read, 0 means write, and it is write after reset. In write direction dp_wr pushes and seq_pop pops. In read direction seq_push pushes and dp_rd pops. A push strobe from the other side is ignored.
- R9: The threshold flag is high in read direction when the level is at least threshold+1, and in write direction when the free entries are at least threshold+1. dma_req is the threshold flag gated by DMA enable.
- R10: Writing 1 to the abort bit sets it, and writing 0 does not clear it. While it is set, seq_abort is high, the FIFO is emptied, pushes are ignored and command writes are refused. The cycle after seq_idle is seen high, abort and busy both return to 0.
- R11: While busy, sck_tick pulses once every prescaler+1 clock cycles. While idle, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| dp_wr | input | 1 | Host byte push (write direction) |
| dp_wdata | input | 8 | Host byte to push |
| dp_rd | input | 1 | Host byte pop (read direction) |
| dp_rdata | output | 8 | FIFO head byte |
| seq_start | output | 1 | One-cycle command start strobe |
| seq_cmd | output | 32 | Accepted command word |
| seq_abort | output | 1 | Abort request held to the sequencer |
| seq_idle | input | 1 | Sequencer reports it has stopped |
| seq_done | input | 1 | Sequencer reports command complete |
| seq_err | input | 1 | Sequencer reports transfer error |
| seq_push | input | 1 | Sequencer byte push (read direction) |
| seq_pdata | input | 8 | Sequencer byte to push |
| seq_pop | input | 1 | Sequencer byte pop (write direction) |
| seq_rdata | output | 8 | FIFO head byte for the sequencer |
| sck_tick | output | 1 | Serial clock enable |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt |

## Verification
The bound checker watches on every cycle that a pending abort with an idle sequencer releases both abort and busy in the next cycle. It also checks that an abort empties the FIFO, that the FIFO level never exceeds its depth, that a command write while busy leaves the command and start strobe alone, and that done/error while busy land in their flags. Data ordering, the two threshold comparisons, the direction-based choice of push source and the tick spacing for a given prescaler depend on multi-cycle stimulus. Only the bench scenarios can show those. The same applies to the readback masking of the control register and the set-beats-clear rule of the flags.

// File: rtl/qspi_ctl_pkg.sv
package qspi_ctl_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFF_CTRL = 4'h0;
    localparam logic [REG_AW-1:0] OFF_STAT = 4'h4;
    localparam logic [REG_AW-1:0] OFF_FCLR = 4'h8;
    localparam logic [REG_AW-1:0] OFF_CMD  = 4'hC;

    localparam int CB_EN    = 0;
    localparam int CB_ABORT = 1;
    localparam int CB_DMA   = 2;
    localparam int CB_THR   = 8;
    localparam int CB_TEIE  = 16;
    localparam int CB_TCIE  = 17;
    localparam int CB_PRESC = 24;

    localparam int CMD_DIR_BIT = 31;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_FCLR,
        SEL_CMD
    } reg_sel_e;

    typedef struct packed {
        logic       busy;
        logic       ftf;
        logic       tcf;
        logic       tef;
        logic [5:0] level;
    } status_t;

    function automatic reg_sel_e decode_sel(input logic [REG_AW-1:0] a);
        case (a)
            OFF_CTRL: return SEL_CTRL;
            OFF_STAT: return SEL_STAT;
            OFF_FCLR: return SEL_FCLR;
            default:  return SEL_CMD;
        endcase
    endfunction

    function automatic logic [31:0] status_word(input status_t s);
        logic [31:0] w;
        w        = '0;
        w[0]     = s.tef;
        w[1]     = s.tcf;
        w[2]     = s.ftf;
        w[5]     = s.busy;
        w[13:8]  = s.level;
        return w;
    endfunction

    function automatic logic [31:0] ctrl_word(
        input logic [7:0] presc,
        input logic       tcie,
        input logic       teie,
        input logic [4:0] thr,
        input logic       dmaen,
        input logic       abort,
        input logic       en
    );
        logic [31:0] w;
        w                        = '0;
        w[CB_EN]                 = en;
        w[CB_ABORT]              = abort;
        w[CB_DMA]                = dmaen;
        w[CB_THR +: 5]           = thr;
        w[CB_TEIE]               = teie;
        w[CB_TCIE]               = tcie;
        w[CB_PRESC +: 8]         = presc;
        return w;
    endfunction

endpackage

// File: rtl/qspi_byte_fifo.sv
module qspi_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     pdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [LVL_W-1:0] lvl_q;
    logic             push_ok, pop_ok;

    assign push_ok = push && (lvl_q != LVL_W'(DEPTH));
    assign pop_ok  = pop && (lvl_q != '0);
    assign head    = mem[rp_q];
    assign level   = lvl_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wp_q] <= pdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_ok) wp_q <= bump(wp_q);
            if (pop_ok)  rp_q <= bump(rp_q);
            case ({push_ok, pop_ok})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/qspi_sck_div.sv
module qspi_sck_div #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    assign tick = run && (cnt_q == presc);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == presc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/qspi_flag_unit.sv
module qspi_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set_tc,
    input  logic set_te,
    input  logic clr_tc,
    input  logic clr_te,
    input  logic tcie,
    input  logic teie,
    output logic tcf,
    output logic tef,
    output logic irq
);
    logic tcf_q, tef_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcf_q <= 1'b0;
            tef_q <= 1'b0;
        end else begin
            if (set_tc)      tcf_q <= 1'b1;
            else if (clr_tc) tcf_q <= 1'b0;
            if (set_te)      tef_q <= 1'b1;
            else if (clr_te) tef_q <= 1'b0;
        end
    end

    assign tcf = tcf_q;
    assign tef = tef_q;
    assign irq = (tcf_q && tcie) || (tef_q && teie);
endmodule

// File: rtl/qspi_ctl_unit.sv
module qspi_ctl_unit
    import qspi_ctl_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int PRESC_W    = 8,
    localparam int THR_W     = $clog2(FIFO_DEPTH),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int CMP_W     = LVL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dp_wr,
    input  logic [7:0]        dp_wdata,
    input  logic              dp_rd,
    output logic [7:0]        dp_rdata,
    output logic              seq_start,
    output logic [31:0]       seq_cmd,
    output logic              seq_abort,
    input  logic              seq_idle,
    input  logic              seq_done,
    input  logic              seq_err,
    input  logic              seq_push,
    input  logic [7:0]        seq_pdata,
    input  logic              seq_pop,
    output logic [7:0]        seq_rdata,
    output logic              sck_tick,
    output logic              dma_req,
    output logic              irq
);
    reg_sel_e sel;
    logic     wr_ctrl, wr_fclr, wr_cmd;

    logic               en_q, dmaen_q, teie_q, tcie_q, abort_q, busy_q, start_q;
    logic [THR_W-1:0]   thr_q;
    logic [PRESC_W-1:0] presc_q;
    logic [31:0]        cmd_q;
    logic               dir_rd, cmd_accept, abort_release;

    logic               fifo_push, fifo_pop;
    logic [7:0]         fifo_pdata, fifo_head;
    logic [LVL_W-1:0]   fifo_level;
    logic               ftf, tcf, tef;
    logic [CMP_W-1:0]   need, lvl_ext, free_ext;
    status_t            stat;

    // register decode
    assign sel     = decode_sel(bus_addr);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign wr_fclr = bus_wr && (sel == SEL_FCLR);
    assign wr_cmd  = bus_wr && (sel == SEL_CMD);

    assign cmd_accept    = wr_cmd && en_q && !busy_q && !abort_q;
    assign abort_release = abort_q && seq_idle;
    assign dir_rd        = cmd_q[CMD_DIR_BIT];

    // control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            dmaen_q <= 1'b0;
            teie_q  <= 1'b0;
            tcie_q  <= 1'b0;
            thr_q   <= '0;
            presc_q <= '0;
        end else if (wr_ctrl) begin
            en_q    <= bus_wdata[CB_EN];
            dmaen_q <= bus_wdata[CB_DMA];
            teie_q  <= bus_wdata[CB_TEIE];
            tcie_q  <= bus_wdata[CB_TCIE];
            thr_q   <= bus_wdata[CB_THR +: THR_W];
            presc_q <= bus_wdata[CB_PRESC +: PRESC_W];
        end
    end

    // abort: set by software, released by hardware once the sequencer stops
    always_ff @(posedge clk) begin
        if (rst) begin
            abort_q <= 1'b0;
        end else if (abort_release) begin
            abort_q <= 1'b0;
        end else if (wr_ctrl && bus_wdata[CB_ABORT]) begin
            abort_q <= 1'b1;
        end
    end

    // command acceptance and busy tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            start_q <= cmd_accept;
            if (cmd_accept) begin
                cmd_q <= bus_wdata;
            end
            if (abort_release) begin
                busy_q <= 1'b0;
            end else if (cmd_accept) begin
                busy_q <= 1'b1;
            end else if (busy_q && (seq_done || seq_err)) begin
                busy_q <= 1'b0;
            end
        end
    end

    // FIFO side selection by direction
    assign fifo_push  = !abort_q && (dir_rd ? seq_push : dp_wr);
    assign fifo_pdata = dir_rd ? seq_pdata : dp_wdata;
    assign fifo_pop   = dir_rd ? dp_rd : seq_pop;

    qspi_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (8)
    ) fifo_u (
        .clk   (clk),
        .rst   (rst),
        .flush (abort_q),
        .push  (fifo_push),
        .pdata (fifo_pdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .level (fifo_level)
    );

    // threshold comparison
    assign need     = CMP_W'(thr_q) + 1'b1;
    assign lvl_ext  = CMP_W'(fifo_level);
    assign free_ext = CMP_W'(FIFO_DEPTH) - lvl_ext;
    assign ftf      = dir_rd ? (lvl_ext >= need) : (free_ext >= need);

    qspi_flag_unit flags_u (
        .clk    (clk),
        .rst    (rst),
        .set_tc (busy_q && seq_done),
        .set_te (busy_q && seq_err),
        .clr_tc (wr_fclr && bus_wdata[1]),
        .clr_te (wr_fclr && bus_wdata[0]),
        .tcie   (tcie_q),
        .teie   (teie_q),
        .tcf    (tcf),
        .tef    (tef),
        .irq    (irq)
    );

    qspi_sck_div #(
        .PW (PRESC_W)
    ) sck_u (
        .clk   (clk),
        .rst   (rst),
        .run   (busy_q),
        .presc (presc_q),
        .tick  (sck_tick)
    );

    // read mux
    always_comb begin
        stat.busy  = busy_q;
        stat.ftf   = ftf;
        stat.tcf   = tcf;
        stat.tef   = tef;
        stat.level = 6'(fifo_level);
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_word(8'(presc_q), tcie_q, teie_q, 5'(thr_q),
                                            dmaen_q, abort_q, en_q);
            SEL_STAT: bus_rdata = status_word(stat);
            SEL_CMD:  bus_rdata = cmd_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign seq_start = start_q;
    assign seq_cmd   = cmd_q;
    assign seq_abort = abort_q;
    assign dp_rdata  = fifo_head;
    assign seq_rdata = fifo_head;
    assign dma_req   = dmaen_q && ftf;
endmodule

// File: rtl/qspi_ctl_unit_chk.sv
module qspi_ctl_unit_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          abort_q,
    input logic          busy_q,
    input logic          seq_idle,
    input logic          seq_done,
    input logic          seq_err,
    input logic          seq_start,
    input logic [31:0]   seq_cmd,
    input logic          wr_cmd,
    input logic          clr_tc,
    input logic          tcf,
    input logic          tef,
    input logic [LW-1:0] fifo_level
);
    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        abort_q && seq_idle |=> !abort_q && !busy_q);

    // R10
    abort_flush_chk: assert property (@(posedge clk) disable iff (rst)
        abort_q |=> fifo_level == '0);

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    // R3
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && wr_cmd |=> $stable(seq_cmd) && !seq_start);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> !seq_start);

    // R4
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && seq_done |=> tcf && !busy_q);

    // R4
    err_flag_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && seq_err |=> tef && !busy_q);

    // R5
    clear_tc_chk: assert property (@(posedge clk) disable iff (rst)
        clr_tc && !(busy_q && seq_done) |=> !tcf);
endmodule

bind qspi_ctl_unit qspi_ctl_unit_chk #(
    .DEPTH (FIFO_DEPTH),
    .LW    (LVL_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .abort_q    (abort_q),
    .busy_q     (busy_q),
    .seq_idle   (seq_idle),
    .seq_done   (seq_done),
    .seq_err    (seq_err),
    .seq_start  (seq_start),
    .seq_cmd    (seq_cmd),
    .wr_cmd     (wr_cmd),
    .clr_tc     (wr_fclr && bus_wdata[1]),
    .tcf        (tcf),
    .tef        (tef),
    .fifo_level (fifo_level)
);

// File: tb/qspi_ctl_unit_tb.sv
module qspi_ctl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dp_wr = 1'b0;
    logic [7:0]  dp_wdata = '0;
    logic        dp_rd = 1'b0;
    logic [7:0]  dp_rdata;
    logic        seq_start;
    logic [31:0] seq_cmd;
    logic        seq_abort;
    logic        seq_idle = 1'b0;
    logic        seq_done = 1'b0;
    logic        seq_err = 1'b0;
    logic        seq_push = 1'b0;
    logic [7:0]  seq_pdata = '0;
    logic        seq_pop = 1'b0;
    logic [7:0]  seq_rdata;
    logic        sck_tick;
    logic        dma_req;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    qspi_ctl_unit dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_wr(dp_wr),
        .dp_wdata(dp_wdata), .dp_rd(dp_rd), .dp_rdata(dp_rdata),
        .seq_start(seq_start), .seq_cmd(seq_cmd), .seq_abort(seq_abort),
        .seq_idle(seq_idle), .seq_done(seq_done), .seq_err(seq_err),
        .seq_push(seq_push), .seq_pdata(seq_pdata), .seq_pop(seq_pop),
        .seq_rdata(seq_rdata), .sck_tick(sck_tick), .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); seq_done = 1'b1;
        @(negedge clk); seq_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h4, v); check("R1 status", v, 32'h4);
        rd(4'hC, v); check("R1 cmd", v, 32'h0);
        check("R1 outputs", {irq, seq_start, seq_abort, sck_tick}, 4'b0000);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(4'h0, 32'hA507_1F05);
        rd(4'h0, v); check("R2 ctrl readback", v, 32'hA503_0F05);
        wr(4'h0, 32'h0003_0001);
        rd(4'h0, v); check("R2 ctrl rewrite", v, 32'h0003_0001);
    endtask

    task automatic t_cmd_flags();
        logic [31:0] v;
        wr(4'hC, 32'h0000_0012);
        check("R3 start pulse", seq_start, 1'b1);
        check("R3 cmd out", seq_cmd, 32'h12);
        rd(4'h4, v); check("R4 busy set", v, 32'h24);
        @(negedge clk);
        check("R3 start single", seq_start, 1'b0);
        wr(4'hC, 32'h0000_0055);
        check("R3 busy refuses", seq_cmd, 32'h12);
        check("R3 no start when busy", seq_start, 1'b0);
        pulse_done();
        rd(4'h4, v); check("R4 done sets tcf", v, 32'h06);
        check("R6 irq on tcf", irq, 1'b1);
        wr(4'h8, 32'h0);
        rd(4'h4, v); check("R5 zero write keeps", v, 32'h06);
        wr(4'h8, 32'h2);
        rd(4'h4, v); check("R5 clear tcf", v, 32'h04);
        check("R6 irq low", irq, 1'b0);
        wr(4'hC, 32'h0000_0013);
        @(negedge clk); seq_err = 1'b1;
        @(negedge clk); seq_err = 1'b0;
        rd(4'h4, v); check("R4 err sets tef", v, 32'h05);
        check("R6 irq on tef", irq, 1'b1);
        wr(4'h0, 32'h0002_0001);
        check("R6 irq masked", irq, 1'b0);
        wr(4'h8, 32'h1);
        rd(4'h4, v); check("R5 clear tef", v, 32'h04);
        wr(4'h0, 32'h0003_0000);
        wr(4'hC, 32'h0000_0077);
        check("R3 disabled refuses", seq_cmd, 32'h13);
        check("R3 disabled no start", seq_start, 1'b0);
        wr(4'h0, 32'h0003_0001);
        wr(4'hC, 32'h0000_0014);
        @(negedge clk);
        bus_addr = 4'h8; bus_wr = 1'b1; bus_wdata = 32'h2; seq_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; seq_done = 1'b0;
        rd(4'h4, v); check("R5 set beats clear", v, 32'h06);
        wr(4'h8, 32'h3);
    endtask

    task automatic t_fifo_wdir();
        logic [31:0] v;
        for (int i = 0; i < 18; i++) begin
            @(negedge clk); dp_wr = 1'b1; dp_wdata = 8'(8'h30 + i);
        end
        @(negedge clk); dp_wr = 1'b0;
        rd(4'h4, v); check("R7 full level", v[13:8], 32'd16);
        check("R9 wdir full no ftf", v[2], 1'b0);
        for (int i = 0; i < 16; i++) begin
            check("R7 order wdir", seq_rdata, 8'(8'h30 + i));
            @(negedge clk); seq_pop = 1'b1;
            @(negedge clk); seq_pop = 1'b0;
        end
        @(negedge clk); seq_pop = 1'b1;
        @(negedge clk); seq_pop = 1'b0;
        rd(4'h4, v); check("R7 empty pop", v[13:8], 32'd0);
    endtask

    task automatic t_fifo_rdir();
        logic [31:0] v;
        wr(4'hC, 32'h8000_0003);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); seq_push = 1'b1; seq_pdata = 8'(8'hA0 + i);
        end
        @(negedge clk); seq_push = 1'b0;
        @(negedge clk); dp_wr = 1'b1; dp_wdata = 8'hEE;
        @(negedge clk); dp_wr = 1'b0;
        rd(4'h4, v); check("R8 rdir ignores host push", v[13:8], 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R8 rdir order", dp_rdata, 8'(8'hA0 + i));
            @(negedge clk); dp_rd = 1'b1;
            @(negedge clk); dp_rd = 1'b0;
        end
        pulse_done();
        wr(4'h8, 32'h3);
    endtask

    task automatic t_threshold();
        logic [31:0] v;
        wr(4'h0, 32'h0003_0305);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); seq_push = 1'b1; seq_pdata = 8'(i);
        end
        @(negedge clk); seq_push = 1'b0;
        rd(4'h4, v); check("R9 rdir below thr", v[2], 1'b0);
        check("R9 dma low", dma_req, 1'b0);
        @(negedge clk); seq_push = 1'b1;
        @(negedge clk); seq_push = 1'b0;
        rd(4'h4, v); check("R9 rdir at thr", v[2], 1'b1);
        check("R9 dma high", dma_req, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); dp_rd = 1'b1;
        end
        @(negedge clk); dp_rd = 1'b0;
        wr(4'hC, 32'h0000_0001);
        pulse_done();
        wr(4'h8, 32'h3);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); dp_wr = 1'b1;
        end
        @(negedge clk); dp_wr = 1'b0;
        rd(4'h4, v); check("R9 wdir free 4", v[2], 1'b1);
        @(negedge clk); dp_wr = 1'b1;
        @(negedge clk); dp_wr = 1'b0;
        rd(4'h4, v); check("R9 wdir free 3", v[2], 1'b0);
        for (int i = 0; i < 13; i++) begin
            @(negedge clk); seq_pop = 1'b1;
        end
        @(negedge clk); seq_pop = 1'b0;
        wr(4'h0, 32'h0003_0001);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(4'hC, 32'h0000_0005);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); dp_wr = 1'b1;
        end
        @(negedge clk); dp_wr = 1'b0;
        wr(4'h0, 32'h0003_0003);
        check("R10 seq_abort", seq_abort, 1'b1);
        @(negedge clk);
        rd(4'h4, v); check("R10 flushed", v[13:8], 32'd0);
        check("R10 still busy", v[5], 1'b1);
        wr(4'h0, 32'h0003_0001);
        rd(4'h0, v); check("R10 zero keeps abort", v[1], 1'b1);
        @(negedge clk); dp_wr = 1'b1;
        @(negedge clk); dp_wr = 1'b0;
        rd(4'h4, v); check("R10 push ignored", v[13:8], 32'd0);
        wr(4'hC, 32'h0000_0066);
        check("R10 cmd refused", seq_cmd, 32'h5);
        @(negedge clk); seq_idle = 1'b1;
        @(negedge clk); seq_idle = 1'b0;
        rd(4'h0, v); check("R10 abort released", v[1], 1'b0);
        rd(4'h4, v); check("R10 busy released", v[5], 1'b0);
        check("R10 seq_abort low", seq_abort, 1'b0);
    endtask

    task automatic t_sck();
        int ticks;
        wr(4'h0, 32'h0300_0001);
        wr(4'hC, 32'h0000_0007);
        ticks = 0;
        for (int i = 0; i < 16; i++) begin
            if (sck_tick) ticks++;
            @(negedge clk);
        end
        check("R11 presc3 ticks", ticks, 4);
        pulse_done();
        ticks = 0;
        for (int i = 0; i < 8; i++) begin
            if (sck_tick) ticks++;
            @(negedge clk);
        end
        check("R11 idle no ticks", ticks, 0);
        wr(4'h8, 32'h3);
        wr(4'h0, 32'h0000_0001);
        wr(4'hC, 32'h0000_0008);
        ticks = 0;
        for (int i = 0; i < 5; i++) begin
            if (sck_tick) ticks++;
            @(negedge clk);
        end
        check("R11 presc0 ticks", ticks, 5);
        pulse_done();
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_cmd_flags();
        t_fifo_wdir();
        t_fifo_rdir();
        t_threshold();
        t_abort();
        t_sck();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule